// File: doc/BRIEF.md
# Fuzzy Rule Strength Max Accumulator

This block sits in the middle stage of a pipelined fuzzy controller. Rules arrive one per clock cycle on a valid/ready stream. Each rule carries four subpremise truth values that the external fuzzifiers have already computed, and the number of the output membership function the rule points at. The block takes the fuzzy AND of the four truths, which is their minimum, as the rule's firing strength. It then folds that strength into one of eight working registers, picked by the output function number. A register is only rewritten when the new strength is larger than the value it holds, so each register keeps the running maximum.

A frame is 256 accepted rules. The frame rate is therefore the rule rate divided by 256. When the last rule of a frame is accepted, the eight maxima (including that last rule) are copied into an output bank for the composition stage, and the working registers are cleared in the same cycle. A one-cycle `frame_done` pulse marks the copy. The output bank holds its contents until the next frame completes, so the downstream stage has a full frame time to consume them.

Back-pressure: `rule_ready` is low while reset is asserted and high in every cycle after the first clock edge out of reset. The block never stalls the stream. A rule is taken on a cycle where `rule_valid` and `rule_ready` are both high. Data presented with `rule_valid` low is ignored.

Top module: `fzacc_rule_accum`

## Requirements
- R1: After reset, `frame_done` is 0, `rule_index` is 0 and all eight bytes of `frame_strength` are 0.
- R2: A rule's firing strength is the minimum of the four 8-bit truth bytes in `rule_truths`. Byte k occupies bits [8k+7:8k].
- R3: Within a frame, the working register selected by `rule_mf` ends up holding the largest firing strength of the accepted rules that named it. It is written only when the new strength is strictly greater than the stored value.
- R4: A rule whose firing strength is 0 leaves every working register unchanged.
- R5: A cycle with `rule_valid` low accepts nothing: the truths and function number on the inputs have no effect on the registers or on `rule_index`.
- R6: `rule_index` counts the rules accepted in the current frame. It steps by one per accepted rule and wraps from 255 to 0.
- R7: On the clock edge that accepts rule 255 of a frame, `frame_strength` is loaded with the eight maxima of that frame, including rule 255. Function number j is held in bits [8j+7:8j]. `frame_done` is high for exactly the following cycle.
- R8: The working registers clear on the same edge as the transfer, so no value from one frame appears in the next frame's output.
- R9: `frame_strength` does not change except on a transfer.
- R10: `rule_ready` is 0 during reset and 1 in every cycle after the first clock edge with reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main rule clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_valid | input | 1 | A rule is present on the stream |
| rule_ready | output | 1 | Block accepts a rule this cycle |
| rule_truths | input | 32 | Four subpremise truth bytes |
| rule_mf | input | 3 | Output membership function number |
| rule_index | output | 8 | Position of the next rule in the frame |
| frame_done | output | 1 | One-cycle pulse after a frame transfer |
| frame_strength | output | 64 | Eight per-function maxima of the last complete frame |

## Verification
The assertions check on every cycle the properties that can be expressed as relations over time. These are: the index holds on idle cycles and steps on accepted ones, `frame_done` follows exactly the acceptance of rule 255 and never lasts two cycles, the output bank stays stable between transfers, and `rule_ready` stays high after reset. The arithmetic can only be shown by the bench's scenarios, which compare whole frames against a reference model. This covers the minimum over four truths, strict-max retention per function number, zero-strength rules, idle data being ignored, the last rule of a frame being included, and earlier frames not leaking into later ones.

// File: rtl/fzacc_pkg.sv
package fzacc_pkg;
  localparam int DEF_TRUTH_W = 8;
  localparam int DEF_N_SUB   = 4;
  localparam int DEF_MF_BITS = 3;
  localparam int DEF_RULES   = 256;
endpackage

// File: rtl/fzacc_min_tree.sv
module fzacc_min_tree #(
  parameter int N_SUB   = 4,
  parameter int TRUTH_W = 8
) (
  input  logic [N_SUB*TRUTH_W-1:0] truths,
  output logic [TRUTH_W-1:0]       strength
);
  logic [TRUTH_W-1:0] chain [N_SUB];

  assign chain[0] = truths[TRUTH_W-1:0];
  for (genvar k = 1; k < N_SUB; k++) begin : g_stage
    logic [TRUTH_W-1:0] cand;
    assign cand     = truths[k*TRUTH_W +: TRUTH_W];
    assign chain[k] = (cand < chain[k-1]) ? cand : chain[k-1];
  end
  assign strength = chain[N_SUB-1];
endmodule

// File: rtl/fzacc_frame_ctr.sv
module fzacc_frame_ctr #(
  parameter int RULES = 256,
  localparam int IDX_W = (RULES > 1) ? $clog2(RULES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RULES - 1);

  assign last = (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/fzacc_bank.sv
module fzacc_bank #(
  parameter int N_MF    = 8,
  parameter int TRUTH_W = 8,
  localparam int SEL_W  = (N_MF > 1) ? $clog2(N_MF) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_en,
  input  logic [SEL_W-1:0]          sel,
  input  logic [TRUTH_W-1:0]        strength,
  input  logic                      flush,
  output logic [N_MF*TRUTH_W-1:0]   hold_bank
);
  logic [TRUTH_W-1:0] work_q [N_MF];
  logic [TRUTH_W-1:0] nxt    [N_MF];
  logic [TRUTH_W-1:0] readback;
  logic               win;

  // read-back multiplexer feeding the max comparator
  assign readback = work_q[sel];
  assign win      = upd_en && (strength > readback);

  for (genvar j = 0; j < N_MF; j++) begin : g_entry
    assign nxt[j] = (win && (sel == SEL_W'(j))) ? strength : work_q[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work_q[j]                          <= '0;
        hold_bank[j*TRUTH_W +: TRUTH_W]    <= '0;
      end else if (flush) begin
        work_q[j]                          <= '0;
        hold_bank[j*TRUTH_W +: TRUTH_W]    <= nxt[j];
      end else begin
        work_q[j]                          <= nxt[j];
      end
    end
  end
endmodule

// File: rtl/fzacc_rule_accum.sv
module fzacc_rule_accum
  import fzacc_pkg::*;
#(
  parameter int TRUTH_W = DEF_TRUTH_W,
  parameter int N_SUB   = DEF_N_SUB,
  parameter int MF_BITS = DEF_MF_BITS,
  parameter int RULES   = DEF_RULES,
  localparam int N_MF   = 1 << MF_BITS,
  localparam int IDX_W  = (RULES > 1) ? $clog2(RULES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rule_valid,
  output logic                     rule_ready,
  input  logic [N_SUB*TRUTH_W-1:0] rule_truths,
  input  logic [MF_BITS-1:0]       rule_mf,
  output logic [IDX_W-1:0]         rule_index,
  output logic                     frame_done,
  output logic [N_MF*TRUTH_W-1:0]  frame_strength
);
  logic               ready_q;
  logic               accept;
  logic               last_rule;
  logic [TRUTH_W-1:0] fire;

  assign rule_ready = ready_q;
  assign accept     = rule_valid && ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      ready_q    <= 1'b1;
      frame_done <= accept && last_rule;
    end
  end

  fzacc_min_tree #(.N_SUB(N_SUB), .TRUTH_W(TRUTH_W)) u_min (
    .truths   (rule_truths),
    .strength (fire)
  );

  fzacc_frame_ctr #(.RULES(RULES)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (accept),
    .idx   (rule_index),
    .last  (last_rule)
  );

  fzacc_bank #(.N_MF(N_MF), .TRUTH_W(TRUTH_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (accept),
    .sel       (rule_mf),
    .strength  (fire),
    .flush     (accept && last_rule),
    .hold_bank (frame_strength)
  );
endmodule

// File: rtl/fzacc_rule_accum_chk.sv
module fzacc_rule_accum_chk #(
  parameter int IDX_W = 8,
  parameter int OUT_W = 64,
  parameter int RULES = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rule_valid,
  input logic             rule_ready,
  input logic [IDX_W-1:0] rule_index,
  input logic             frame_done,
  input logic [OUT_W-1:0] frame_strength
);
  logic acc;
  assign acc = rule_valid && rule_ready;

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(rule_index)); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rule_index != IDX_W'(RULES-1)) |=> rule_index == $past(rule_index) + 1'b1); // R6

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rule_index == IDX_W'(RULES-1)) |=> (rule_index == '0) && frame_done); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(frame_strength)); // R9

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rule_ready); // R10
endmodule

bind fzacc_rule_accum fzacc_rule_accum_chk #(
  .IDX_W(IDX_W), .OUT_W(N_MF*TRUTH_W), .RULES(RULES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rule_valid     (rule_valid),
  .rule_ready     (rule_ready),
  .rule_index     (rule_index),
  .frame_done     (frame_done),
  .frame_strength (frame_strength)
);

// File: tb/test_fzacc_rule_accum.sv
module test_fzacc_rule_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rule_valid = 1'b0;
  logic        rule_ready;
  logic [31:0] rule_truths = '0;
  logic [2:0]  rule_mf = '0;
  logic [7:0]  rule_index;
  logic        frame_done;
  logic [63:0] frame_strength;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] prev_exp [8];

  always #5 clk = ~clk;

  fzacc_rule_accum i_fzacc_rule_accum (
    .clk(clk), .rst_n(rst_n), .rule_valid(rule_valid), .rule_ready(rule_ready),
    .rule_truths(rule_truths), .rule_mf(rule_mf), .rule_index(rule_index),
    .frame_done(frame_done), .frame_strength(frame_strength)
  );

  function automatic logic [7:0] min4(input logic [31:0] t);
    logic [7:0] m = t[7:0];
    for (int k = 1; k < 4; k++) if (t[k*8 +: 8] < m) m = t[k*8 +: 8];
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req, input logic [7:0] e [8]);
    for (int j = 0; j < 8; j++) check(req, 64'(frame_strength[j*8 +: 8]), 64'(e[j]));
  endtask

  // mode 0 directed, 1 random with idle gaps, 2 small random, 3 single function descending
  task automatic run_frame(input int mode);
    logic [7:0] exp [8];
    logic [31:0] t;
    logic [2:0]  m;
    for (int j = 0; j < 8; j++) exp[j] = 8'd0;
    for (int i = 0; i < 256; i++) begin
      if (mode == 1 && ($urandom % 4) == 0) begin
        @(negedge clk);
        rule_valid  = 1'b0;           // R5: idle data must be ignored
        rule_truths = 32'hFFFF_FFFF;
        rule_mf     = 3'($urandom);
      end
      case (mode)
        0: begin
          m = 3'(i % 8);
          t = {8'(255 - i), (m == 3'd7) ? 8'd0 : 8'((i*53 + 7) % 256),
               8'((i*91 + 13) % 256), 8'((i*37) % 256)};
          if (i == 255) begin m = 3'd3; t = 32'hFFFF_FFFF; end
        end
        1: begin t = $urandom; m = 3'($urandom); end
        2: begin t = $urandom & 32'h0F0F_0F0F; m = 3'($urandom); end
        default: begin
          m = 3'd5;
          t = {8'(255 - i), 8'(255 - i), 8'd255, 8'(255 - i)};
        end
      endcase
      @(negedge clk);
      if (i == 100) begin
        check("R6 index mid-frame", 64'(rule_index), 64'd100);
        check_bank("R9 output held mid-frame", prev_exp);
      end
      rule_valid  = 1'b1;
      rule_truths = t;
      rule_mf     = m;
      if (min4(t) > exp[m]) exp[m] = min4(t);
    end
    @(negedge clk);
    rule_valid = 1'b0;
    check("R7 frame_done pulse", 64'(frame_done), 64'd1);
    check("R6 index wrap", 64'(rule_index), 64'd0);
    check_bank("R7/R2/R3/R4/R8 frame maxima", exp);
    @(negedge clk);
    check("R7 frame_done one cycle", 64'(frame_done), 64'd0);
    check_bank("R9 output held after transfer", exp);
    for (int j = 0; j < 8; j++) prev_exp[j] = exp[j];
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240517);
    for (int j = 0; j < 8; j++) prev_exp[j] = 8'd0;
    repeat (3) @(negedge clk);
    check("R10 ready low in reset", 64'(rule_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 frame_done reset", 64'(frame_done), 64'd0);
    check("R1 index reset", 64'(rule_index), 64'd0);
    check("R1 bank reset", frame_strength, 64'd0);
    check("R10 ready high", 64'(rule_ready), 64'd1);
    run_frame(0);
    run_frame(1);
    run_frame(2);
    run_frame(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule